// File: doc/BRIEF.md
# Eight-Line Vectored Priority Interrupt Controller

This block gathers eight external request lines and turns them into one group interrupt with an 8-bit vector. Each line is captured on a change to its active level. The active level is chosen by software for all eight lines at once. Captured requests sit in a request register, and a mask register can hide any of them. When software or a host processor acknowledges the interrupt, the best pending line moves from the request register to the in-service register, and its programmed vector comes out on the next cycle.

Software drives the block through one 8-bit write port and one 8-bit read port, with an address bit that picks a port:
- The control port takes commands on write and returns status on read.
- The data port moves whichever register the mode bits currently select.

Two modes change how the next line is chosen:
- Fixed priority, where the lowest line index wins.
- Rotating priority, where the line just serviced drops to the bottom.

A per-line auto-clear register lets chosen lines skip the in-service stage. Such a line then never blocks later requests.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After the reset input, and after the control-port command 0x00, the mask register is 0xFF, the mode register is 0x00 and the request register is 0x00. A command reset leaves the vector memory unchanged.
- R2: A request bit is set when its line moves from inactive to active. Mode bit 4 sets the active level: 1 = high, 0 = low. A line held active sets its bit only once.
- R3: A control-port command byte has its opcode in bits 7:5 and a line index in bits 2:0. The opcodes are:
  - 001 clears one request bit.
  - 010 sets one request bit.
  - 011 clears one mask bit.
  - 100 sets one mask bit.
  - 101 clears one in-service bit.
  - 110 loads mode bits 4:0 from data bits 4:0, with mode bit 3 forced to 0.
  - 111 preselects a vector entry.
  - 000 with bit 4 set loads mode bits 7:5 from data bits 2:0.
- R4: The data port reads and writes the register selected by mode bits 6:5: 00 = in-service, 01 = mask, 10 = request, 11 = auto-clear.
- R5: The group interrupt output is high only when all of these hold:
  - a request is pending, unmasked and not blocked by the in-service fence;
  - mode bit 7 is 1 (armed);
  - mode bit 2 is 0 (interrupt mode);
  - the enable-in input is high;
  - the interrupt-enable input is high.
- R6: An acknowledge while the group interrupt is high picks the winning line, clears its request bit and sets its in-service bit. In the next cycle, the vector valid output is high for one cycle with that line's vector entry. In fixed mode (mode bit 0 = 0), line 0 has the highest priority.
- R7: In fixed mode, a set in-service bit k blocks lines k and above from raising the group interrupt. Lines below k can still raise it.
- R8: In rotating mode (mode bit 0 = 1), any set in-service bit blocks all lines. After line k is serviced, line k+1 has the highest priority and line k the lowest.
- R9: A line whose auto-clear bit is set leaves its in-service bit clear when acknowledged, so it raises no fence.
- R10: In common-vector mode (mode bit 1 = 1), every acknowledge returns vector entry 0.
- R11: Status byte layout:
  - bit 7 is 0 when any unmasked request bit is set, and 1 otherwise;
  - bit 6 is enable-in;
  - bit 5 is mode bit 0;
  - bit 4 is mode bit 2;
  - bit 3 is mode bit 7;
  - bits 2:0 are 0.
- R12: After a vector preselect command for entry i, the next data-port write loads entry i and no other register.
- R13: In polled mode (mode bit 2 = 1), the group interrupt stays low while status bit 7 still reports pending requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | 8 | Request lines |
| sel | input | 1 | Port select: 0 = control port, 1 = data port |
| wr | input | 1 | Write strobe for the selected port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: status (sel=0) or the preselected register (sel=1) |
| ack | input | 1 | Acknowledge strobe |
| int_en | input | 1 | External interrupt enable |
| en_in | input | 1 | Enable-in from an upstream controller |
| grp_int | output | 1 | Group interrupt request |
| vec_valid | output | 1 | Vector present, one cycle after an accepted acknowledge |
| vec | output | VW | Vector of the acknowledged line |

## Verification
The assertions check four behaviours on every cycle:
- the group interrupt never rises while the block is disarmed or polled;
- the group interrupt never rises without an unmasked request;
- rotating mode with a set in-service bit never raises the group interrupt;
- each vector follows an acknowledge and adds at most one in-service bit.

Only the bench scenarios can show which line wins, the vector value it returns, the rotation order and the fixed-mode fence between line pairs. The bench sweeps every line and every pair of lines. The auto-clear, common-vector, polarity and command-reset cases need sequences of register writes, so the bench covers them as well.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    irq,
  input  logic          sel,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          ack,
  input  logic          int_en,
  input  logic          en_in,
  output logic          grp_int,
  output logic          vec_valid,
  output logic [VW-1:0] vec
);
  localparam int NL = 8;
  localparam int IW = $clog2(NL);

  logic [NL-1:0] irr, imr, isr, acr, prev_act;
  logic [NL-1:0] irr_n, imr_n, isr_n, acr_n;
  logic [7:0]    mode, mode_n;
  logic [IW-1:0] top, vidx, win, top_eff;
  logic          vpre;
  logic [VW-1:0] mem [NL];

  logic [NL-1:0] act, rise, fence, elig, line_bit, sel_reg;
  logic          pend, ack_ok, cmd_wr, dat_wr;
  logic [2:0]    op;

  assign act      = mode[4] ? irq : ~irq;
  assign rise     = act & ~prev_act;
  assign cmd_wr   = wr & ~sel;
  assign dat_wr   = wr & sel;
  assign op       = wdata[7:5];
  assign line_bit = NL'(1) << wdata[IW-1:0];
  assign top_eff  = mode[0] ? top : '0;

  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int i = 0; i < NL; i++) begin
      blk = blk | isr[i];
      fence[i] = mode[0] ? ~|isr : ~blk;
    end
  end

  assign elig = irr & ~imr & fence;
  assign pend = |elig;

  always_comb begin
    logic [IW-1:0] idx;
    win = '0;
    for (int k = NL - 1; k >= 0; k--) begin
      idx = top_eff + IW'(k);
      if (elig[idx]) win = idx;
    end
  end

  assign grp_int = pend & mode[7] & ~mode[2] & en_in & int_en;
  assign ack_ok  = ack & grp_int;

  always_comb begin
    case (mode[6:5])
      2'b00:   sel_reg = isr;
      2'b01:   sel_reg = imr;
      2'b10:   sel_reg = irr;
      default: sel_reg = acr;
    endcase
  end

  assign rdata = sel ? sel_reg
                     : {~|(irr & ~imr), en_in, mode[0], mode[2], mode[7], 3'b000};

  always_comb begin
    irr_n  = irr | rise;
    imr_n  = imr;
    isr_n  = isr;
    acr_n  = acr;
    mode_n = mode;
    if (cmd_wr) begin
      case (op)
        3'd0: if (wdata == 8'h00) begin
                irr_n  = '0;
                imr_n  = '1;
                mode_n = '0;
              end else if (wdata[4]) begin
                mode_n[7:5] = wdata[2:0];
              end
        3'd1: irr_n = irr_n & ~line_bit;
        3'd2: irr_n = irr_n | line_bit;
        3'd3: imr_n = imr_n & ~line_bit;
        3'd4: imr_n = imr_n | line_bit;
        3'd5: isr_n = isr_n & ~line_bit;
        3'd6: mode_n[4:0] = {wdata[4], 1'b0, wdata[2:0]};
        default: ;
      endcase
    end
    if (dat_wr && !vpre) begin
      case (mode[6:5])
        2'b00:   isr_n = wdata;
        2'b01:   imr_n = wdata;
        2'b10:   irr_n = wdata;
        default: acr_n = wdata;
      endcase
    end
    if (ack_ok) begin
      irr_n[win] = 1'b0;
      isr_n[win] = isr_n[win] | ~acr[win];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr       <= '0;
      imr       <= '1;
      isr       <= '0;
      acr       <= '0;
      mode      <= '0;
      prev_act  <= '1;
      top       <= '0;
      vpre      <= 1'b0;
      vidx      <= '0;
      vec       <= '0;
      vec_valid <= 1'b0;
    end else begin
      irr       <= irr_n;
      imr       <= imr_n;
      isr       <= isr_n;
      acr       <= acr_n;
      mode      <= mode_n;
      prev_act  <= act;
      vec_valid <= ack_ok;
      if (ack_ok) vec <= mode[1] ? mem[0] : mem[win];
      if (ack_ok && mode[0]) top <= win + IW'(1);
      if (cmd_wr && op == 3'd7) begin
        vpre <= 1'b1;
        vidx <= wdata[IW-1:0];
      end else if (dat_wr && vpre) begin
        vpre <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dat_wr && vpre) mem[vidx] <= wdata[VW-1:0];
  end

  // R5 R13
  armed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_int |-> (mode[7] && !mode[2]));

  // R5
  unmasked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_int |-> ((irr & ~imr) != '0));

  // R8
  rot_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && isr != '0) |-> !grp_int);

  // R6
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(ack) && $past(grp_int)));

  // R6
  one_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !$past(wr)) |-> $onehot0(isr & ~$past(isr)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = 8'h00;
  logic       sel = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       int_en = 1'b1, en_in = 1'b1;
  logic [7:0] rdata, vec;
  logic       grp_int, vec_valid;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.VW(8)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq(irq), .sel(sel), .wr(wr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .int_en(int_en), .en_in(en_in),
    .grp_int(grp_int), .vec_valid(vec_valid), .vec(vec)
  );

  function automatic logic [7:0] vv(int i);
    return 8'h40 + 8'(i * 4);
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic ctl(logic [7:0] v);
    sel = 1'b0; wr = 1'b1; wdata = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic dwr(logic [7:0] v);
    sel = 1'b1; wr = 1'b1; wdata = v;
    @(negedge clk);
    wr = 1'b0; sel = 1'b0;
  endtask

  task automatic rd(logic s, output logic [7:0] v);
    sel = s; #1; v = rdata; sel = 1'b0;
  endtask

  task automatic pulse(logic [7:0] m);
    irq = irq | m;  @(negedge clk);
    irq = irq & ~m; @(negedge clk);
  endtask

  task automatic do_ack(string req, logic [7:0] exp);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(req, {7'd0, vec_valid}, 8'd1);
    chk(req, vec, exp);
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, r); chk("R1 R11 status after reset", r, 8'hC0);
    rd(1'b1, r); chk("R1 isr after reset", r, 8'h00);
    ctl(8'h11);
    rd(1'b1, r); chk("R1 imr after reset", r, 8'hFF);
    chk("R5 no int after reset", {7'd0, grp_int}, 8'd0);

    for (int i = 0; i < 8; i++) begin
      ctl(8'hE0 | 8'(i));
      dwr(vv(i));
    end
    ctl(8'hD0);
    ctl(8'h15);
    for (int i = 0; i < 8; i++) ctl(8'h60 | 8'(i));
    rd(1'b1, r); chk("R3 R12 imr cleared, vector writes kept out", r, 8'h00);

    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      chk("R2 R5 edge raises int", {7'd0, grp_int}, 8'd1);
      do_ack("R6 single line vector", vv(i));
      chk("R7 own fence", {7'd0, grp_int}, 8'd0);
      ctl(8'hA0 | 8'(i));
    end

    for (int a = 0; a < 7; a++)
      for (int b = a + 1; b < 8; b++) begin
        pulse(8'((1 << a) | (1 << b)));
        chk("R5 pair int", {7'd0, grp_int}, 8'd1);
        do_ack("R6 fixed winner", vv(a));
        chk("R7 lower line fenced", {7'd0, grp_int}, 8'd0);
        ctl(8'hA0 | 8'(a));
        chk("R7 fence lifted", {7'd0, grp_int}, 8'd1);
        do_ack("R6 second line", vv(b));
        ctl(8'hA0 | 8'(b));
        chk("R6 pair drained", {7'd0, grp_int}, 8'd0);
      end

    pulse(8'h08);
    do_ack("R6 line 3", vv(3));
    pulse(8'h02);
    chk("R7 higher line passes fence", {7'd0, grp_int}, 8'd1);
    do_ack("R7 nested vector", vv(1));
    ctl(8'hA1); ctl(8'hA3);

    irq = 8'h02; @(negedge clk);
    do_ack("R2 held line", vv(1));
    ctl(8'hA1);
    repeat (3) @(negedge clk);
    chk("R2 held line captured once", {7'd0, grp_int}, 8'd0);
    irq = 8'h00; @(negedge clk);

    ctl(8'h83);
    pulse(8'h08);
    chk("R5 masked line", {7'd0, grp_int}, 8'd0);
    rd(1'b0, r); chk("R11 status masked", r, 8'hC8);
    ctl(8'h63);
    chk("R5 unmasked line", {7'd0, grp_int}, 8'd1);
    rd(1'b0, r); chk("R11 status pending", r, 8'h48);
    int_en = 1'b0; #1;
    chk("R5 int_en low", {7'd0, grp_int}, 8'd0);
    int_en = 1'b1; en_in = 1'b0; #1;
    chk("R5 en_in low", {7'd0, grp_int}, 8'd0);
    rd(1'b0, r); chk("R11 status en_in", r, 8'h08);
    en_in = 1'b1;
    ctl(8'h11);
    chk("R5 disarmed", {7'd0, grp_int}, 8'd0);
    rd(1'b0, r); chk("R11 status disarmed", r, 8'h40);
    ctl(8'h15);
    do_ack("R5 rearmed", vv(3));
    ctl(8'hA3);

    ctl(8'hD4);
    pulse(8'h40);
    chk("R13 polled no int", {7'd0, grp_int}, 8'd0);
    rd(1'b0, r); chk("R13 R11 polled status", r, 8'h58);
    ctl(8'h26);
    rd(1'b0, r); chk("R3 R13 clear irr bit", r, 8'hD8);
    ctl(8'h44);
    rd(1'b0, r); chk("R3 set irr bit", r, 8'h58);
    ctl(8'h24);
    ctl(8'hD0);

    ctl(8'hD1);
    rd(1'b0, r); chk("R11 status rotating", r, 8'hE8);
    pulse(8'h24);
    do_ack("R8 rotating first", vv(2));
    chk("R8 rotating blocks", {7'd0, grp_int}, 8'd0);
    ctl(8'hA2);
    do_ack("R8 rotating second", vv(5));
    pulse(8'h02);
    chk("R8 higher line blocked", {7'd0, grp_int}, 8'd0);
    ctl(8'hA5);
    do_ack("R8 after rotate", vv(1));
    ctl(8'hA1);
    pulse(8'h41);
    do_ack("R8 line 6 ahead of 0", vv(6));
    ctl(8'hA6);
    do_ack("R8 then line 0", vv(0));
    ctl(8'hA0);
    pulse(8'h81);
    do_ack("R8 line 7 ahead of 0", vv(7));
    ctl(8'hA7);
    do_ack("R8 line 0 last", vv(0));
    ctl(8'hA0);

    ctl(8'hD0);
    ctl(8'h17);
    dwr(8'h08);
    rd(1'b1, r); chk("R4 acr readback", r, 8'h08);
    pulse(8'h28);
    do_ack("R9 auto-clear line", vv(3));
    chk("R9 no fence", {7'd0, grp_int}, 8'd1);
    do_ack("R9 next line", vv(5));
    ctl(8'h14);
    rd(1'b1, r); chk("R9 R4 isr only line 5", r, 8'h20);
    ctl(8'hA5);
    rd(1'b1, r); chk("R3 isr cleared", r, 8'h00);
    ctl(8'h17); dwr(8'h00);

    ctl(8'hD2);
    pulse(8'h10);
    do_ack("R10 common vector", vv(0));
    ctl(8'hA4);
    ctl(8'hD0);

    irq = 8'hFF; @(negedge clk);
    ctl(8'h00);
    rd(1'b0, r); chk("R1 status after command reset", r, 8'hC0);
    ctl(8'h12);
    rd(1'b1, r); chk("R1 irr after command reset", r, 8'h00);
    ctl(8'h11);
    rd(1'b1, r); chk("R1 imr after command reset", r, 8'hFF);
    irq = 8'h00; @(negedge clk);
    ctl(8'hD0);
    ctl(8'h16);
    dwr(8'h00);
    rd(1'b1, r); chk("R4 irr written by data port", r, 8'h00);
    for (int i = 0; i < 8; i++) ctl(8'h60 | 8'(i));
    pulse(8'h04);
    do_ack("R1 vectors kept over command reset", vv(2));
    ctl(8'hA2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule